// File: doc/BRIEF.md
# Mode-Selectable UART Transmit Path

This block is the transmit half of a serial port channel. A host pushes bytes in through a one-cycle write strobe. The bytes wait in a holding FIFO. A frame shifter takes the oldest byte, wraps it in a serial frame and drives it on a single line. Each frame has a low start bit, five to eight data bits sent least-significant first, an optional parity bit and one or two high stop bits. Every bit lasts sixteen baud-tick pulses.

One storage array of 128 entries backs the FIFO. How much of it may be filled depends on a compatibility mode chosen at run time from three configuration bits. The modes give a one-byte holding register, a 16-entry FIFO, or the full 128 entries in either of two enhanced modes. A write that arrives when the active limit is reached is dropped and raises a sticky overrun flag. Changing the mode empties the FIFO, so no stale entry can sit above the new limit.

The block reports the FIFO fill level, the overrun flag and a line-idle status. Frame format settings are captured when each byte is loaded into the shifter.

Top module: `uart_tx_path`

## Requirements
- R1: With `cfg_enh`=0 the value of `cfg_spec` is ignored: toggling it neither flushes the FIFO nor changes the limit. The depth limit is 1 entry when `cfg_fifo_en`=0 and 16 entries when `cfg_fifo_en`=1.
- R2: With `cfg_enh`=1 the depth limit is 128 entries for both `cfg_spec`=0 (enhanced 550) and `cfg_spec`=1 (enhanced 950).
- R3: Bytes are transmitted in the order they were accepted. When the shifter is free and the FIFO is not empty, the head byte moves into the shifter and leaves the FIFO on the same clock edge.
- R4: A write while `fifo_level` equals the active limit is discarded, and `fifo_level` stays at the limit. Such a write sets `overrun`, which stays set until an `ovr_clr` pulse. If a drop and a clear happen in the same cycle, the flag is set.
- R5: A change of the decoded mode empties the FIFO and clears `overrun` on the next edge. A write in that cycle is discarded without raising `overrun`.
- R6: The line idles at 1 and each frame is laid out as follows. A start bit of 0 comes first. Next come N data bits, LSB first, where N = 5 + `cfg_data_bits` (codes 0..3 give 5..8 bits). If `cfg_par_en`=1, a parity bit follows; it makes the count of ones over the data and parity bits even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1. Last come one stop bit of 1, or two when `cfg_two_stop`=1.
- R7: Each bit of a frame lasts exactly 16 clock cycles in which `baud_tick` is high. While `baud_tick` is low, `txd` holds its value.
- R8: `tx_idle` is 1 only when no frame is being shifted and the FIFO is empty.
- R9: After reset, `txd`=1, `fifo_level`=0, `overrun`=0 and `tx_idle`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enh | input | 1 | Enhanced-function enable |
| cfg_spec | input | 1 | Special-function mode select (used only when `cfg_enh`=1) |
| cfg_fifo_en | input | 1 | FIFO enable for the legacy modes (0 gives byte mode, 1 gives 16 entries) |
| cfg_data_bits | input | 2 | Data length code, N = 5 + code |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to queue |
| ovr_clr | input | 1 | Clears the overrun flag |
| txd | output | 1 | Serial output |
| fifo_level | output | 8 | Entries held in the FIFO |
| overrun | output | 1 | Sticky flag for a dropped write |
| tx_idle | output | 1 | Shifter done and FIFO empty |

## Verification
On every cycle, the assertions check four things. The fill level stays within the active limit once any flush has taken effect. A dropped write raises the flag on the next edge. A mode change leaves an empty FIFO with the flag clear. The line stays frozen whenever no baud tick arrives. Only the bench scenarios can show the rest. They confirm the exact depth at which each of the four modes starts dropping, that a toggle of the special bit in legacy mode has no effect, and that bytes come out in the order written. They also decode every frame bit for the random data lengths, parity senses and stop counts.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    MODE_BYTE   = 2'd0,
    MODE_FIFO16 = 2'd1,
    MODE_ENH550 = 2'd2,
    MODE_ENH950 = 2'd3
  } tx_mode_e;
endpackage

// File: rtl/tx_mode_decode.sv
module tx_mode_decode
  import uart_tx_pkg::*;
#(
  parameter int DEEP_DEPTH = 128,
  parameter int MID_DEPTH  = 16,
  localparam int LW = $clog2(DEEP_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enh,
  input  logic          spec,
  input  logic          fifo_en,
  output tx_mode_e      mode,
  output logic [LW-1:0] limit,
  output logic          flush
);
  tx_mode_e mode_d, mode_q;

  always_comb begin
    if (!enh) mode_d = fifo_en ? MODE_FIFO16 : MODE_BYTE;
    else      mode_d = spec ? MODE_ENH950 : MODE_ENH550;
  end

  always_comb begin
    case (mode_d)
      MODE_BYTE:   limit = LW'(1);
      MODE_FIFO16: limit = LW'(MID_DEPTH);
      default:     limit = LW'(DEEP_DEPTH);
    endcase
  end

  assign flush = (mode_d != mode_q);
  assign mode  = mode_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_BYTE;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/tx_hold_fifo.sv
module tx_hold_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [LW-1:0] limit,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          ovr_clr,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          overrun
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0] level_d;
  logic          ovr_d, wr_ok, drop, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign wr_ok  = wr_en && !flush && (level < limit);
  assign drop   = wr_en && !flush && (level >= limit);
  assign pop_ok = pop && !flush && (level != '0);
  assign head   = mem[rptr_q];

  always_comb begin
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    level_d = level;
    ovr_d   = overrun;
    if (flush) begin
      wptr_d  = '0;
      rptr_d  = '0;
      level_d = '0;
      ovr_d   = 1'b0;
    end else begin
      if (wr_ok)  wptr_d = bump(wptr_q);
      if (pop_ok) rptr_d = bump(rptr_q);
      case ({wr_ok, pop_ok})
        2'b10:   level_d = level + LW'(1);
        2'b01:   level_d = level - LW'(1);
        default: level_d = level;
      endcase
      if (drop)         ovr_d = 1'b1;
      else if (ovr_clr) ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      level   <= level_d;
      overrun <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= wr_data;
  end

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> level <= limit);
  assert_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun);
  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0) && !overrun);
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer #(
  parameter int DW  = 8,
  parameter int OVS = 16,
  localparam int FW   = DW + 4,
  localparam int BL_W = $clog2(FW + 1),
  localparam int TW   = $clog2(OVS),
  localparam int MIN_BITS = DW - 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic [1:0]    data_bits,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          two_stop,
  input  logic          avail,
  input  logic [DW-1:0] head,
  output logic          pop,
  output logic          txd,
  output logic          busy
);
  logic [FW-1:0]   sr_q, sr_d, frame;
  logic [BL_W-1:0] left_q, left_d, flen, nbits, ppos;
  logic [TW-1:0]   tick_q, tick_d;
  logic            busy_d, par;

  always_comb begin
    nbits = BL_W'(data_bits) + BL_W'(MIN_BITS);
    ppos  = nbits + BL_W'(1);
    frame = '1;
    frame[0] = 1'b0;
    par = par_odd;
    for (int i = 0; i < DW; i++) begin
      if (i < int'(nbits)) begin
        frame[1 + i] = head[i];
        par = par ^ head[i];
      end
    end
    if (par_en) frame[ppos] = par;
    flen = nbits + BL_W'(2) + BL_W'(par_en) + BL_W'(two_stop);
  end

  assign pop = !busy && avail;
  assign txd = busy ? sr_q[0] : 1'b1;

  always_comb begin
    sr_d   = sr_q;
    left_d = left_q;
    tick_d = tick_q;
    busy_d = busy;
    if (pop) begin
      sr_d   = frame;
      left_d = flen;
      tick_d = '0;
      busy_d = 1'b1;
    end else if (busy && baud_tick) begin
      if (tick_q == TW'(OVS - 1)) begin
        tick_d = '0;
        sr_d   = {1'b1, sr_q[FW-1:1]};
        left_d = left_q - BL_W'(1);
        if (left_q == BL_W'(1)) busy_d = 1'b0;
      end else begin
        tick_d = tick_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '1;
      left_q <= '0;
      tick_q <= '0;
      busy   <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      left_q <= left_d;
      tick_q <= tick_d;
      busy   <= busy_d;
    end
  end

  assert_hold_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !baud_tick |=> $stable(txd));
  assert_load_starts_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> busy && !txd);
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_tx_pkg::*;
#(
  parameter int DEEP_DEPTH = 128,
  parameter int MID_DEPTH  = 16,
  parameter int DW         = 8,
  parameter int OVS        = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_enh,
  input  logic                              cfg_spec,
  input  logic                              cfg_fifo_en,
  input  logic [1:0]                        cfg_data_bits,
  input  logic                              cfg_par_en,
  input  logic                              cfg_par_odd,
  input  logic                              cfg_two_stop,
  input  logic                              baud_tick,
  input  logic                              wr_en,
  input  logic [DW-1:0]                     wr_data,
  input  logic                              ovr_clr,
  output logic                              txd,
  output logic [$clog2(DEEP_DEPTH + 1)-1:0] fifo_level,
  output logic                              overrun,
  output logic                              tx_idle
);
  localparam int LW = $clog2(DEEP_DEPTH + 1);

  tx_mode_e      mode;
  logic [LW-1:0] limit;
  logic          flush, pop, busy;
  logic [DW-1:0] head;

  tx_mode_decode #(.DEEP_DEPTH(DEEP_DEPTH), .MID_DEPTH(MID_DEPTH)) u_mode (
    .clk(clk), .rst_n(rst_n), .enh(cfg_enh), .spec(cfg_spec),
    .fifo_en(cfg_fifo_en), .mode(mode), .limit(limit), .flush(flush)
  );

  tx_hold_fifo #(.DEPTH(DEEP_DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .limit(limit),
    .wr_en(wr_en), .wr_data(wr_data), .ovr_clr(ovr_clr), .pop(pop),
    .head(head), .level(fifo_level), .overrun(overrun)
  );

  tx_serializer #(.DW(DW), .OVS(OVS)) u_ser (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .data_bits(cfg_data_bits), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .two_stop(cfg_two_stop), .avail(fifo_level != '0), .head(head),
    .pop(pop), .txd(txd), .busy(busy)
  );

  assign tx_idle = !busy && (fifo_level == '0);

  assert_idle_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> txd);
  assert_mode_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enh && !flush && $stable(cfg_enh) && $stable(cfg_fifo_en) |->
      (mode == MODE_BYTE || mode == MODE_FIFO16));
endmodule

// File: tb/uart_tx_path_test.sv
module uart_tx_path_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_enh, cfg_spec, cfg_fifo_en;
  logic [1:0] cfg_data_bits;
  logic       cfg_par_en, cfg_par_odd, cfg_two_stop;
  logic       baud_tick, wr_en, ovr_clr;
  logic [7:0] wr_data;
  logic       txd, overrun, tx_idle;
  logic [7:0] fifo_level;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_tx_path uut (
    .clk(clk), .rst_n(rst_n), .cfg_enh(cfg_enh), .cfg_spec(cfg_spec),
    .cfg_fifo_en(cfg_fifo_en), .cfg_data_bits(cfg_data_bits),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .ovr_clr(ovr_clr), .txd(txd),
    .fifo_level(fifo_level), .overrun(overrun), .tx_idle(tx_idle)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int depth_of(input int m);
    if (m == 0) return 1;
    if (m == 1) return 16;
    return 128;
  endfunction

  function automatic logic par_of(input logic [7:0] b, input int n, input logic odd);
    logic p = odd;
    for (int i = 0; i < n; i++) p ^= b[i];
    return p;
  endfunction

  task automatic set_mode(input int m);
    @(negedge clk);
    cfg_enh     = (m >= 2);
    cfg_spec    = (m == 3);
    cfg_fifo_en = (m == 1);
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Decodes one frame on txd (ticks every cycle) and checks it against b (R6, R7)
  task automatic rx_frame(input logic [7:0] b);
    int n = 5 + int'(cfg_data_bits);
    int guard = 0;
    while (txd !== 1'b0 && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    repeat (8) @(negedge clk);
    chk("R6 start bit", int'(txd), 0);
    for (int j = 0; j < n; j++) begin
      repeat (16) @(negedge clk);
      chk("R3/R6/R7 data bit", int'(txd), int'(b[j]));
    end
    if (cfg_par_en) begin
      repeat (16) @(negedge clk);
      chk("R6 parity bit", int'(txd), int'(par_of(b, n, cfg_par_odd)));
    end
    repeat (16) @(negedge clk);
    chk("R6 stop bit", int'(txd), 1);
    if (cfg_two_stop) begin
      repeat (16) @(negedge clk);
      chk("R6 second stop bit", int'(txd), 1);
    end
  endtask

  task automatic run_mode(input int m);
    logic [7:0] q[$];
    int d = depth_of(m);
    set_mode(m);
    baud_tick = 1'b0;
    {cfg_par_odd, cfg_par_en, cfg_two_stop} = 3'($urandom);
    cfg_data_bits = 2'($urandom);
    repeat (3) @(negedge clk);
    chk("R5 level after mode select", int'(fifo_level), 0);
    for (int i = 0; i <= d; i++) q.push_back(8'($urandom));
    write_byte(q[0]);
    repeat (2) @(negedge clk);
    chk("R3 head moved to shifter", int'(fifo_level), 0);
    chk("R8 not idle while shifting", int'(tx_idle), 0);
    for (int i = 1; i <= d; i++) write_byte(q[i]);
    chk((m < 2) ? "R1 level at limit" : "R2 level at limit", int'(fifo_level), d);
    chk("R4 no overrun yet", int'(overrun), 0);
    write_byte(8'($urandom));
    chk("R4 overrun set", int'(overrun), 1);
    chk("R4 level saturated", int'(fifo_level), d);
    repeat (20) @(negedge clk);
    chk("R7 line frozen without ticks", int'(txd), 0);
    chk("R4 overrun sticky", int'(overrun), 1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    chk("R4 overrun cleared", int'(overrun), 0);
    baud_tick = 1'b1;
    foreach (q[k]) rx_frame(q[k]);
    repeat (20) @(negedge clk);
    chk("R8 idle after drain", int'(tx_idle), 1);
    chk("R8 level after drain", int'(fifo_level), 0);
    chk("R8 line high after drain", int'(txd), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b0;
    void'($urandom(32'd2718));
    rst_n = 1'b0;
    {cfg_enh, cfg_spec, cfg_fifo_en, cfg_par_en, cfg_par_odd, cfg_two_stop} = '0;
    cfg_data_bits = 2'd3;
    baud_tick = 1'b0; wr_en = 1'b0; ovr_clr = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R9 txd in reset", int'(txd), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 level after reset", int'(fifo_level), 0);
    chk("R9 overrun after reset", int'(overrun), 0);
    chk("R9 idle after reset", int'(tx_idle), 1);
    chk("R9 line after reset", int'(txd), 1);

    for (int m = 0; m < 4; m++) run_mode(m);

    // R1: cfg_spec ignored in legacy mode; R5: mode change flushes
    set_mode(1);
    baud_tick = 1'b0;
    cfg_data_bits = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
    repeat (3) @(negedge clk);
    b0 = 8'hA5;
    write_byte(b0);
    repeat (2) @(negedge clk);
    write_byte(8'h11);
    write_byte(8'h22);
    chk("R1 level before spec toggle", int'(fifo_level), 2);
    @(negedge clk); cfg_spec = ~cfg_spec;
    repeat (2) @(negedge clk);
    chk("R1 spec ignored, level kept", int'(fifo_level), 2);
    for (int i = 0; i < 15; i++) write_byte(8'($urandom));
    chk("R1 16-deep limit reached", int'(fifo_level), 16);
    chk("R4 overrun in FIFO16", int'(overrun), 1);
    @(negedge clk); cfg_enh = 1'b1;
    @(negedge clk);
    chk("R5 flush empties FIFO", int'(fifo_level), 0);
    chk("R5 flush clears overrun", int'(overrun), 0);
    baud_tick = 1'b1;
    rx_frame(b0);
    repeat (20) @(negedge clk);
    chk("R8 idle after flush and drain", int'(tx_idle), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule